// File: doc/BRIEF.md
# Posted Write Buffer with Bypass

This block sits between a processor core's data port and an external system bus. Writes whose address lies in the external space are posted into a four-entry queue, so the core moves on at once. The queue drains to the bus by itself, oldest first, through a valid/ready master handshake. Two programmable address windows, plus one fixed window, mark writes as "immediate". Such a write takes a separate slot and is offered to the bus before any queued entry that has not yet been offered. It either holds the core until it completes (freeze) or lets the core continue (no-freeze).

Reads are not carried by this block. It only watches them for ordering. A read into external space that names a word still held in the queue raises a flush: the core is held and the whole queue is written out before the read may go. A read is also held while an immediate write is outstanding, so a read issued right after an immediate write always follows it on the bus.

Top module: `posted_wbuf`

## Requirements
- R1: A write at or above 0x00F00000 with a normal attribute is accepted without stalling the core while fewer than four entries are held. Each entry keeps its address, data and byte enables.
- R2: Writes and reads below 0x00F00000 are ignored: no stall, no bus transfer.
- R3: A normal external write arriving while four entries are held stalls the core until an entry has drained and a slot is free.
- R4: Queued entries leave in arrival order, one per cycle with bus_valid and bus_ready both high. While bus_valid is high and bus_ready is low, bus_addr, bus_data and bus_be stay unchanged.
- R5: Each window is given by a base, a size and a 2-bit mode; an address hits when base <= addr < base+size. Mode 2'b01 means freeze-immediate and 2'b10 means no-freeze-immediate; 2'b00 and 2'b11 mean normal. Window 0 is checked before window 1.
- R6: A freeze-immediate write is offered before every queued entry not yet offered. The core stalls until that write's transfer completes, and the stall drops in the completion cycle.
- R7: A no-freeze-immediate write is offered before every queued entry not yet offered and is accepted with no stall.
- R8: Addresses 0x00F08000 through 0x00F0FFFF are freeze-immediate whatever the windows say.
- R9: An external read whose word address matches a held entry raises bus_flush and stalls. The stall lasts until the queue is empty; a read that matches nothing is not stalled.
- R10: An external read is stalled while an immediate write is outstanding and is released only after that write's transfer.
- R11: An immediate write arriving while another immediate write is outstanding stalls until the slot has been freed by that transfer.
- R12: After reset, bus_valid, bus_flush and core_stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req | input | 1 | Core access request, held while stalled |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Byte address |
| core_wdata | input | DATA_W | Write data |
| core_be | input | DATA_W/8 | Byte enables |
| core_stall | output | 1 | Core must hold its request |
| rgn0_base | input | ADDR_W | Window 0 base |
| rgn0_size | input | ADDR_W | Window 0 size in bytes |
| rgn0_mode | input | 2 | Window 0 mode |
| rgn1_base | input | ADDR_W | Window 1 base |
| rgn1_size | input | ADDR_W | Window 1 size in bytes |
| rgn1_mode | input | 2 | Window 1 mode |
| bus_valid | output | 1 | Write transfer offered |
| bus_addr | output | ADDR_W | Transfer address |
| bus_data | output | DATA_W | Transfer data |
| bus_be | output | DATA_W/8 | Transfer byte enables |
| bus_flush | output | 1 | Top-priority flush request |
| bus_ready | input | 1 | Bus accepts the offered transfer |

## Verification
A corrupted pointer or count in the queue shows at the ports as a wrong or repeated bus_addr/bus_data on the next accepted transfer, or as a stall that comes or goes one cycle off. The bench models these outputs every cycle, so such an error is caught in the cycle it first reaches a port. A stuck immediate-slot flag or flush flag shows as a core_stall that never drops, or as a read released while entries remain. The directed checks also compare the order of completed transfers against the expected order for each overtaking case.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        K_NORM = 2'd0,
        K_FRZ  = 2'd1,
        K_NF   = 2'd2
    } kind_e;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_IMM    = 2'b01;
    localparam logic [1:0] MODE_IMM_NF = 2'b10;
endpackage

// File: rtl/pwb_classify.sv
module pwb_classify
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 2,
    parameter logic [ADDR_W-1:0] EXT_BASE = 32'h00F0_0000,
    parameter logic [ADDR_W-1:0] FIX_LO   = 32'h00F0_8000,
    parameter logic [ADDR_W-1:0] FIX_HI   = 32'h00F0_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] rbase [NREG],
    input  logic [ADDR_W-1:0] rsize [NREG],
    input  logic [1:0]        rmode [NREG],
    output logic              is_ext,
    output kind_e             kind
);
    logic [NREG-1:0] win_hit;

    for (genvar g = 0; g < NREG; g++) begin : g_win
        assign win_hit[g] = (addr - rbase[g]) < rsize[g];
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        kind   = K_NORM;
        is_ext = addr >= EXT_BASE;
        for (int r = 0; r < NREG; r++) begin
            if (!found && win_hit[r]) begin
                found = 1'b1;
                case (rmode[r])
                    MODE_IMM:    kind = K_FRZ;
                    MODE_IMM_NF: kind = K_NF;
                    default:     kind = K_NORM;
                endcase
            end
        end
        if (addr >= FIX_LO && addr <= FIX_HI) kind = K_FRZ;
    end
endmodule

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = 4,
    parameter int DEPTH = 4,
    parameter int OFF   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [BW-1:0] in_be,
    input  logic          pop,
    output logic [AW-1:0] hd_addr,
    output logic [DW-1:0] hd_data,
    output logic [BW-1:0] hd_be,
    output logic          empty,
    output logic          full,
    output logic          drained,
    input  logic [AW-1:OFF] look_word,
    output logic          hit
);
    localparam int EW = AW + DW + BW;
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef logic [EW-1:0] ent_t;
    typedef struct packed {
        ent_t [DEPTH-1:0] mem;
        logic [PW-1:0]    wp;
        logic [PW-1:0]    rp;
        logic [CW-1:0]    cnt;
    } fst_t;

    fst_t f_q, f_d;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.mem[f_q.wp] = {in_addr, in_data, in_be};
            f_d.wp = nxt(f_q.wp);
        end
        if (pop) f_d.rp = nxt(f_q.rp);
        f_d.cnt = f_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign {hd_addr, hd_data, hd_be} = f_q.mem[f_q.rp];
    assign empty   = f_q.cnt == '0;
    assign full    = f_q.cnt == CW'(DEPTH);
    assign drained = f_d.cnt == '0;

    always_comb begin
        int ofs;
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            ofs = (i >= int'(f_q.rp)) ? i - int'(f_q.rp) : i + DEPTH - int'(f_q.rp);
            if (ofs < int'(f_q.cnt) && f_q.mem[i][EW-1 -: (AW-OFF)] == look_word)
                hit = 1'b1;
        end
    end

    // R3: the occupancy never passes the depth
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(DEPTH));
    // R3: the controller never pushes into a full queue
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |-> !push);
endmodule

// File: rtl/posted_wbuf.sv
module posted_wbuf
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter logic [ADDR_W-1:0] EXT_BASE = 32'h00F0_0000,
    parameter logic [ADDR_W-1:0] FIX_LO   = 32'h00F0_8000,
    parameter logic [ADDR_W-1:0] FIX_HI   = 32'h00F0_FFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_req,
    input  logic                core_we,
    input  logic [ADDR_W-1:0]   core_addr,
    input  logic [DATA_W-1:0]   core_wdata,
    input  logic [DATA_W/8-1:0] core_be,
    output logic                core_stall,
    input  logic [ADDR_W-1:0]   rgn0_base,
    input  logic [ADDR_W-1:0]   rgn0_size,
    input  logic [1:0]          rgn0_mode,
    input  logic [ADDR_W-1:0]   rgn1_base,
    input  logic [ADDR_W-1:0]   rgn1_size,
    input  logic [1:0]          rgn1_mode,
    output logic                bus_valid,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_data,
    output logic [DATA_W/8-1:0] bus_be,
    output logic                bus_flush,
    input  logic                bus_ready
);
    localparam int BE_W = DATA_W / 8;
    localparam int OFF  = (BE_W > 1) ? $clog2(BE_W) : 0;
    localparam int NREG = 2;

    typedef struct packed {
        logic              imm_v;
        logic              hold;
        logic              lock;
        logic              lock_imm;
        logic              flush;
        logic [ADDR_W-1:0] ia;
        logic [DATA_W-1:0] id;
        logic [BE_W-1:0]   ib;
    } ctl_t;

    ctl_t s_q, s_d;

    logic [ADDR_W-1:0] rbase [NREG];
    logic [ADDR_W-1:0] rsize [NREG];
    logic [1:0]        rmode [NREG];
    assign rbase[0] = rgn0_base;
    assign rsize[0] = rgn0_size;
    assign rmode[0] = rgn0_mode;
    assign rbase[1] = rgn1_base;
    assign rsize[1] = rgn1_size;
    assign rmode[1] = rgn1_mode;

    logic  is_ext;
    kind_e kind;

    pwb_classify #(
        .ADDR_W(ADDR_W), .NREG(NREG),
        .EXT_BASE(EXT_BASE), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI)
    ) u_cls (
        .addr(core_addr), .rbase(rbase), .rsize(rsize), .rmode(rmode),
        .is_ext(is_ext), .kind(kind)
    );

    logic              push, pop, q_empty, q_full, q_drained, q_hit;
    logic [ADDR_W-1:0] hd_addr;
    logic [DATA_W-1:0] hd_data;
    logic [BE_W-1:0]   hd_be;

    pwb_fifo #(
        .AW(ADDR_W), .DW(DATA_W), .BW(BE_W), .DEPTH(DEPTH), .OFF(OFF)
    ) u_q (
        .clk(clk), .rst_n(rst_n),
        .push(push), .in_addr(core_addr), .in_data(core_wdata), .in_be(core_be),
        .pop(pop),
        .hd_addr(hd_addr), .hd_data(hd_data), .hd_be(hd_be),
        .empty(q_empty), .full(q_full), .drained(q_drained),
        .look_word(core_addr[ADDR_W-1:OFF]), .hit(q_hit)
    );

    logic wr, rd, rd_hit, sel_imm, fire, imm_done, load;

    always_comb begin
        wr      = core_req && core_we && is_ext;
        rd      = core_req && !core_we && is_ext;
        rd_hit  = rd && q_hit;
        sel_imm = s_q.lock ? s_q.lock_imm : s_q.imm_v;

        bus_valid = sel_imm ? s_q.imm_v : !q_empty;
        bus_addr  = sel_imm ? s_q.ia : hd_addr;
        bus_data  = sel_imm ? s_q.id : hd_data;
        bus_be    = sel_imm ? s_q.ib : hd_be;
        bus_flush = s_q.flush || rd_hit;

        fire     = bus_valid && bus_ready;
        pop      = fire && !sel_imm;
        imm_done = fire && sel_imm;

        push       = 1'b0;
        load       = 1'b0;
        core_stall = 1'b0;
        if (wr) begin
            case (kind)
                K_NF: begin
                    core_stall = s_q.imm_v;
                    load       = !s_q.imm_v;
                end
                K_FRZ: begin
                    if (s_q.hold) begin
                        core_stall = !imm_done;
                    end else begin
                        core_stall = 1'b1;
                        load       = !s_q.imm_v;
                    end
                end
                default: begin
                    core_stall = q_full;
                    push       = !q_full;
                end
            endcase
        end else if (rd) begin
            core_stall = rd_hit || s_q.flush || s_q.imm_v;
        end

        s_d          = s_q;
        s_d.lock     = bus_valid && !bus_ready;
        s_d.lock_imm = sel_imm;
        s_d.flush    = (s_q.flush || rd_hit) && !q_drained;
        if (imm_done) begin
            s_d.imm_v = 1'b0;
            s_d.hold  = 1'b0;
        end
        if (load) begin
            s_d.imm_v = 1'b1;
            s_d.hold  = (kind == K_FRZ);
            s_d.ia    = core_addr;
            s_d.id    = core_wdata;
            s_d.ib    = core_be;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: an offered transfer is held steady until the bus takes it
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data) && $stable(bus_be));
    // R6: a fresh immediate entry is never passed by a queue pop
    assert_imm_overtake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.imm_v && !s_q.lock |-> !pop);
    // R6: a frozen core always has its write sitting in the slot
    assert_freeze_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hold |-> s_q.imm_v);
    // R9: while a flush is pending and entries remain, an external read is held
    assert_flush_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flush && !q_empty && rd |-> core_stall);
    // R10: no external read passes an outstanding immediate write
    assert_read_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.imm_v && rd |-> core_stall);
endmodule

// File: tb/posted_wbuf_test.sv
module posted_wbuf_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE   = 32'h00F0_0000;
    localparam logic [31:0] FIX_LO = 32'h00F0_8000;
    localparam logic [31:0] FIX_HI = 32'h00F0_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        core_req = 0, core_we = 0;
    logic [31:0] core_addr = 0, core_wdata = 0;
    logic [3:0]  core_be = 0;
    logic        core_stall;
    logic [31:0] r0b = 0, r0s = 0, r1b = 0, r1s = 0;
    logic [1:0]  r0m = 0, r1m = 0;
    logic        bus_valid, bus_flush;
    logic [31:0] bus_addr, bus_data;
    logic [3:0]  bus_be;
    logic        bus_ready = 0;

    posted_wbuf uut (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_be(core_be), .core_stall(core_stall),
        .rgn0_base(r0b), .rgn0_size(r0s), .rgn0_mode(r0m),
        .rgn1_base(r1b), .rgn1_size(r1s), .rgn1_mode(r1m),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_be(bus_be), .bus_flush(bus_flush), .bus_ready(bus_ready)
    );

    int    tests = 0, fails = 0;
    string cur_tag = "R12";
    bit    finished = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // bus ready pattern, updated just after each rising edge
    bit rdy_on = 0;
    int rdy_div = 1;
    int cyc = 0;
    always begin
        @(posedge clk);
        #1;
        cyc++;
        bus_ready = rdy_on && (cyc % rdy_div == 0);
    end

    // log of completed transfers, taken at the ports
    logic [31:0] xlog[$];
    always @(negedge clk)
        if (rst_n && bus_valid && bus_ready) xlog.push_back(bus_addr);

    // behavioural reference: 0 internal, 1 normal, 2 freeze, 3 no-freeze
    function automatic int kind_of(logic [31:0] a);
        int k;
        if (a < BASE) return 0;
        k = 1;
        if (a - r0b < r0s)      k = (r0m == 2'b01) ? 2 : (r0m == 2'b10) ? 3 : 1;
        else if (a - r1b < r1s) k = (r1m == 2'b01) ? 2 : (r1m == 2'b10) ? 3 : 1;
        if (a >= FIX_LO && a <= FIX_HI) k = 2;
        return k;
    endfunction

    typedef struct { logic [31:0] a; logic [31:0] d; logic [3:0] b; } ent_t;
    ent_t mq[$];
    ent_t m_imm;
    bit   m_imm_v, m_hold, m_lock, m_lock_imm, m_flush;

    always @(negedge clk) begin
        int   k;
        bit   wr, rd, sel, ev, fire, hit, st, psh, ld;
        ent_t eh;
        if (!rst_n) begin
            mq.delete();
            m_imm_v = 0; m_hold = 0; m_lock = 0; m_lock_imm = 0; m_flush = 0;
        end else begin
            k   = kind_of(core_addr);
            wr  = core_req && core_we && k != 0;
            rd  = core_req && !core_we && k != 0;
            sel = m_lock ? m_lock_imm : m_imm_v;
            ev  = sel ? m_imm_v : (mq.size() != 0);
            eh  = sel ? m_imm : ((mq.size() != 0) ? mq[0] : '{32'h0, 32'h0, 4'h0});
            fire = ev && bus_ready;
            hit = 0;
            foreach (mq[i]) if (rd && mq[i].a[31:2] == core_addr[31:2]) hit = 1;
            st = 0; psh = 0; ld = 0;
            if (wr) begin
                if (k == 3)      begin st = m_imm_v; ld = !m_imm_v; end
                else if (k == 2) begin
                    if (m_hold) st = !(fire && sel);
                    else begin st = 1; ld = !m_imm_v; end
                end
                else begin st = (mq.size() == 4); psh = !st; end
            end else if (rd) begin
                st = hit || m_flush || m_imm_v;
            end
            chk({cur_tag, " bus_valid"}, bus_valid, ev);
            chk({cur_tag, " core_stall"}, core_stall, st);
            chk({cur_tag, " bus_flush"}, bus_flush, m_flush || hit);
            if (ev) begin
                chk({cur_tag, " bus_addr"}, bus_addr, eh.a);
                chk({cur_tag, " bus_data"}, bus_data, eh.d);
                chk({cur_tag, " bus_be"}, bus_be, eh.b);
            end
            m_lock = ev && !bus_ready;
            m_lock_imm = sel;
            if (fire && sel) begin m_imm_v = 0; m_hold = 0; end
            if (fire && !sel) void'(mq.pop_front());
            if (psh) mq.push_back('{core_addr, core_wdata, core_be});
            if (ld) begin
                m_imm = '{core_addr, core_wdata, core_be};
                m_imm_v = 1;
                m_hold = (k == 2);
            end
            m_flush = (m_flush || hit) && mq.size() != 0;
        end
    end

    // one core access; returns the number of stalled cycles
    task automatic op(bit we, logic [31:0] a, logic [31:0] d, output int ns);
        core_req = 1; core_we = we; core_addr = a; core_wdata = d;
        core_be = d[3:0] | 4'h1;
        ns = 0;
        forever begin
            @(negedge clk);
            if (!core_stall) break;
            ns++;
        end
        @(posedge clk);
        #1 core_req = 0;
    endtask

    task automatic drain(int n);
        for (int i = 0; i < 200 && xlog.size() < n; i++) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_order(string tag, logic [31:0] e0, logic [31:0] e1, logic [31:0] e2, int n);
        chk({tag, " transfer count"}, xlog.size(), n);
        if (xlog.size() >= 1) chk({tag, " transfer 0"}, xlog[0], e0);
        if (n >= 2 && xlog.size() >= 2) chk({tag, " transfer 1"}, xlog[1], e1);
        if (n >= 3 && xlog.size() >= 3) chk({tag, " transfer 2"}, xlog[2], e2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        int ns;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        chk("R12 bus_valid", bus_valid, 0);
        chk("R12 core_stall", core_stall, 0);
        chk("R12 bus_flush", bus_flush, 0);
        idle(1);

        // R2: internal accesses ignored
        cur_tag = "R2"; rdy_on = 1; xlog.delete();
        op(1, 32'h00EF_FFFC, 32'h11, ns); chk("R2 internal write stall", ns, 0);
        op(0, 32'h0000_1000, 32'h0, ns);  chk("R2 internal read stall", ns, 0);
        idle(5);
        chk("R2 no transfer", xlog.size(), 0);

        // R1 R3 R4: fill, overflow, in-order drain
        cur_tag = "R3"; rdy_on = 0; xlog.delete(); idle(2);
        for (int i = 0; i < 4; i++) begin
            op(1, 32'h1000_0000 + 32'(i*16), 32'hA0 + 32'(i), ns);
            chk("R1 posted write stall", ns, 0);
        end
        fork
            op(1, 32'h1000_0040, 32'hA4, ns);
            begin
                repeat (3) begin @(negedge clk); chk("R3 stall while full", core_stall, 1); end
                rdy_on = 1;
            end
        join
        chk("R3 stalled at least 3 cycles", ns >= 3, 1);
        cur_tag = "R4";
        drain(5);
        chk_order("R4", 32'h1000_0000, 32'h1000_0010, 32'h1000_0020, 5);
        if (xlog.size() == 5) begin
            chk("R4 transfer 3", xlog[3], 32'h1000_0030);
            chk("R4 transfer 4", xlog[4], 32'h1000_0040);
        end

        // R7: no-freeze immediate overtakes without stall
        cur_tag = "R7"; r0b = 32'h2000_0000; r0s = 32'h1000; r0m = 2'b10;
        r1b = 32'h3000_0000; r1s = 32'h100; r1m = 2'b01;
        rdy_on = 0; xlog.delete(); idle(2);
        op(1, 32'h1000_0100, 32'hB1, ns);
        op(1, 32'h1000_0200, 32'hB2, ns);
        op(1, 32'h2000_0010, 32'hB3, ns); chk("R7 no-freeze stall", ns, 0);
        rdy_on = 1;
        drain(3);
        chk_order("R7", 32'h1000_0100, 32'h2000_0010, 32'h1000_0200, 3);

        // R6: freeze immediate via window 1
        cur_tag = "R6"; rdy_on = 0; xlog.delete(); idle(2);
        op(1, 32'h1000_0300, 32'hC1, ns);
        op(1, 32'h1000_0400, 32'hC2, ns);
        fork
            op(1, 32'h3000_0020, 32'hC3, ns);
            begin
                repeat (4) begin @(negedge clk); chk("R6 core frozen", core_stall, 1); end
                rdy_on = 1;
            end
        join
        chk("R6 transfers at release", xlog.size(), 2);
        if (xlog.size() >= 2) chk("R6 immediate done at release", xlog[1], 32'h3000_0020);
        drain(3);
        chk_order("R6", 32'h1000_0300, 32'h3000_0020, 32'h1000_0400, 3);

        // R5 R8: mode 11 is normal, fixed window always freezes
        cur_tag = "R8"; r0m = 2'b11; r1m = 2'b00;
        rdy_on = 0; xlog.delete(); idle(2);
        op(1, 32'h2000_0040, 32'hD1, ns); chk("R5 mode 11 no stall", ns, 0);
        op(1, 32'h00F1_0000, 32'hD2, ns); chk("R8 above window no stall", ns, 0);
        fork
            op(1, 32'h00F0_8010, 32'hD3, ns);
            begin
                repeat (3) begin @(negedge clk); chk("R8 fixed window frozen", core_stall, 1); end
                rdy_on = 1;
            end
        join
        drain(3);
        chk_order("R5 R8", 32'h2000_0040, 32'h00F0_8010, 32'h00F1_0000, 3);
        xlog.delete();
        op(1, 32'h00F0_FFFC, 32'hD4, ns); chk("R8 top of window waits", ns, 1);
        op(1, 32'h00F0_7FFC, 32'hD5, ns); chk("R8 below window no stall", ns, 0);
        drain(2);
        chk_order("R8 edges", 32'h00F0_FFFC, 32'h00F0_7FFC, 32'h0, 2);

        // R9: read hit flushes the queue
        cur_tag = "R9"; rdy_on = 0; xlog.delete(); idle(2);
        op(1, 32'h4000_0000, 32'hE1, ns);
        op(1, 32'h4000_0010, 32'hE2, ns);
        op(1, 32'h4000_0020, 32'hE3, ns);
        op(0, 32'h4000_0030, 32'h0, ns); chk("R9 miss read no stall", ns, 0);
        fork
            op(0, 32'h4000_0012, 32'h0, ns);
            begin
                repeat (2) begin
                    @(negedge clk);
                    chk("R9 read hit stall", core_stall, 1);
                    chk("R9 flush raised", bus_flush, 1);
                end
                rdy_div = 2; rdy_on = 1;
            end
        join
        chk("R9 all drained before read", xlog.size(), 3);
        chk("R9 queue empty", bus_valid, 0);
        rdy_div = 1;

        // R10: read right after an immediate write waits for it
        cur_tag = "R10"; r0m = 2'b10; rdy_on = 0; xlog.delete(); idle(2);
        op(1, 32'h2000_0080, 32'hF1, ns); chk("R10 no-freeze accepted", ns, 0);
        fork
            op(0, 32'h5000_0000, 32'h0, ns);
            begin
                repeat (3) begin @(negedge clk); chk("R10 read held", core_stall, 1); end
                rdy_on = 1;
            end
        join
        chk("R10 immediate before read", xlog.size(), 1);
        if (xlog.size() >= 1) chk("R10 immediate address", xlog[0], 32'h2000_0080);

        // R11: second immediate waits for the slot
        cur_tag = "R11"; rdy_on = 0; xlog.delete(); idle(2);
        op(1, 32'h2000_0100, 32'hF2, ns); chk("R11 first accepted", ns, 0);
        fork
            op(1, 32'h2000_0200, 32'hF3, ns);
            begin
                repeat (3) begin @(negedge clk); chk("R11 second held", core_stall, 1); end
                rdy_on = 1;
            end
        join
        drain(2);
        chk_order("R11", 32'h2000_0100, 32'h2000_0200, 32'h0, 2);

        idle(4);
        finish_up();
    end
endmodule